// File: doc/BRIEF.md
# Function-Select Arithmetic, Logic and Shift Unit

A purely combinational function unit for a register-transfer datapath. Two operands `a` and `b` of parameterised width enter, and a 4-bit function code picks one of fifteen operations. The result `f` leaves together with four status flags: overflow `v`, carry `c`, negative `n` and zero `z`.

All eight arithmetic operations share one adder of the form A + Y + carry-in. The function code picks Y from four functions of B: zero, B, the complement of B, or all ones. The lowest code bit is the carry-in. Four bitwise operations work on A and B. A single-place shifter acts on B and fills the vacated bit with zero. The unit holds no state. The surrounding datapath applies a code for one cycle and captures `f` and the flags at the next clock edge.

Top module: `fs_func_unit`

## Requirements
- R1: Codes 0000..0111 give, modulo 2^W: 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A+~B+1 (A−B), 0110 A−1, 0111 A. Code bits [2:1] select Y as 00 zero, 01 B, 10 ~B, 11 all ones. Code bit [0] is the carry-in.
- R2: For codes 0000..0111, `c` is the carry out of the W-bit addition A+Y+cin. `v` is the XOR of the carry into the MSB and the carry out of the MSB.
- R3: Code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R4: Code 1100 passes B unchanged. Code 1101 shifts B right by one place with a 0 in the MSB. Code 1110 shifts B left by one place with a 0 in the LSB.
- R5: For every code with bit 3 set, `c` and `v` are both 0.
- R6: Code 1111 gives F = 0.
- R7: `n` equals F[W-1], and `z` is 1 exactly when F is all zeros, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Operand A |
| b | input | W | Operand B, also the shifter input |
| fs | input | 4 | Function code |
| f | output | W | Result |
| v | output | 1 | Signed overflow of the adder |
| c | output | 1 | Carry out of the adder |
| n | output | 1 | Sign of the result |
| z | output | 1 | Result is zero |

## Verification
The bench applies every function code to random operands and to the edge operands zero, all ones, 0x7F and 0x80. Those edge operands expose a wrong carry for A−1 with A = 0 and for code 0111, which must always report a carry. They also expose a wrong overflow at the signed limits, such as 0x7F+1 or 0x80−1, where a faulty design reports the flag inverted. Shifts of 0x80 and 0x01 reveal a fill bit taken from the wrong place or a shift in the wrong direction, because they leave a stray bit or drop the expected one. Code 1111 and the logic codes catch a design that leaks adder flags or leaves the unused code undefined.

// File: rtl/fs_func_unit.sv
module fs_func_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fs,
  output logic [W-1:0] f,
  output logic         v,
  output logic         c,
  output logic         n,
  output logic         z
);
  logic [W-1:0] y, lg, sh;
  logic [W:0]   sum;
  logic [W-1:0] low;

  always_comb begin
    case (fs[2:1])
      2'b00:   y = '0;
      2'b01:   y = b;
      2'b10:   y = ~b;
      default: y = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, fs[0]};
  assign low = {1'b0, a[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, fs[0]};

  always_comb begin
    case (fs[1:0])
      2'b00:   lg = a & b;
      2'b01:   lg = a | b;
      2'b10:   lg = a ^ b;
      default: lg = ~a;
    endcase
  end

  always_comb begin
    case (fs[1:0])
      2'b00:   sh = b;
      2'b01:   sh = {1'b0, b[W-1:1]};
      2'b10:   sh = {b[W-2:0], 1'b0};
      default: sh = '0;
    endcase
  end

  assign f = fs[3] ? (fs[2] ? sh : lg) : sum[W-1:0];
  assign c = ~fs[3] & sum[W];
  assign v = ~fs[3] & (sum[W] ^ low[W-1]);
  assign n = f[W-1];
  assign z = ~|f;
endmodule

module fs_func_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   fs,
  input logic [W-1:0] f,
  input logic         v,
  input logic         c,
  input logic         n,
  input logic         z
);
  always_comb begin
    if (fs == 4'b0000) assert_pass_a_R1: assert (f == a && !c && !v);
    if (fs == 4'b0010) assert_add_carry_R2: assert ({c, f} == {1'b0, a} + {1'b0, b});
    if (fs == 4'b1000) assert_and_R3: assert (f == (a & b));
    if (fs == 4'b1101) assert_shr_fill_R4: assert (!f[W-1] && f[W-2:0] == b[W-1:1]);
    if (fs[3]) assert_no_flags_R5: assert (!c && !v);
    if (fs == 4'b1111) assert_unused_zero_R6: assert (f == '0 && z);
    if (z) assert_zero_not_neg_R7: assert (!n);
  end
endmodule

bind fs_func_unit fs_func_unit_chk #(.W(W)) u_chk (.*);

// File: tb/fs_func_unit_test.sv
`timescale 1ns/1ps
module fs_func_unit_test;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, f;
  logic [3:0] fs;
  logic v, c, n, z;
  int compared = 0, mismatched = 0;
  bit done = 0;

  fs_func_unit #(.W(W)) uut (.a(a), .b(b), .fs(fs), .f(f), .v(v), .c(c), .n(n), .z(z));

  function automatic string tag(input int code);
    if (code < 8) return "R1/R2";
    if (code < 12) return "R3/R5";
    if (code < 15) return "R4/R5";
    return "R6/R5";
  endfunction

  task automatic apply(input int ai, input int bi, input int code);
    int ef, ec, ev, yv, tot, lowsum, cin;
    @(negedge clk);
    a = W'(ai); b = W'(bi); fs = 4'(code);
    ef = 0; ec = 0; ev = 0;
    cin = code & 1;
    if (code < 8) begin
      case ((code >> 1) & 3)
        0: yv = 0;
        1: yv = bi;
        2: yv = (M - 1) - bi;
        default: yv = M - 1;
      endcase
      tot = ai + yv + cin;
      ef = tot % M;
      ec = tot / M;
      lowsum = (ai % (M / 2)) + (yv % (M / 2)) + cin;
      ev = ec ^ (lowsum / (M / 2));
    end else begin
      case (code)
        8:  ef = ai & bi;
        9:  ef = ai | bi;
        10: ef = ai ^ bi;
        11: ef = (M - 1) - ai;
        12: ef = bi;
        13: ef = bi / 2;
        14: ef = (bi * 2) % M;
        default: ef = 0;
      endcase
    end
    @(posedge clk); #1;
    compared++;
    if (int'(f) != ef || int'(c) != ec || int'(v) != ev) begin
      mismatched++;
      $display("FAIL %s fs=%b a=%h b=%h: f=%h c=%0d v=%0d expected f=%h c=%0d v=%0d",
               tag(code), fs, a, b, f, c, v, ef[W-1:0], ec, ev);
    end
    compared++;
    if (int'(n) != ((ef >> (W - 1)) & 1) || int'(z) != (ef == 0 ? 1 : 0)) begin
      mismatched++;
      $display("FAIL R7 fs=%b a=%h b=%h: n=%0d z=%0d expected n=%0d z=%0d",
               fs, a, b, n, z, (ef >> (W - 1)) & 1, ef == 0);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int edges[5] = '{0, M - 1, M / 2 - 1, M / 2, 1};
    a = '0; b = '0; fs = '0;
    for (int code = 0; code < 16; code++) begin
      foreach (edges[i])
        foreach (edges[j])
          apply(edges[i], edges[j], code);
      for (int k = 0; k < 40; k++)
        apply(int'($urandom_range(M - 1)), int'($urandom_range(M - 1)), code);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule